// File: doc/BRIEF.md
# Adaptive One-Time Memory Programming Sequencer

This block sits on the host side of the programming port of a one-time programmable memory and loads a run of bytes into it. A run starts with an address range from zero up to an end address. The block waits for the supply to settle. It then selects the address-clear mode and asks for the programming supplies through a request/acknowledge pair. After that it loads the memory one byte at a time. Each byte comes from a valid/ready source.

Each byte is written with fixed-length write pulses. After every pulse the block reads the byte back in verify mode and compares it with the value it wrote. When the read-back does not match, the block tries again on the same address. Once the byte matches, the block applies one extra write. That write lasts one pulse unit for each attempt the byte needed. The block then steps the memory's internal address with four clock pulses on the X1 line.

After the last byte, the block clears the address again, drops the supply request and raises `done`. If a byte is still wrong when the attempt limit is reached, the run stops. The block then raises `fail` and reports the failing address.

Top module: `prom_wv_seq`

## Requirements
- R1: After reset the mode lines read 0000, and X1, `bus_oe`, `supply_req`, `src_ready`, `done` and `fail` are all low.
- R2: A start first holds the mode lines at 0000 for exactly POWER_WAIT cycles. The block then selects clear mode (MD0..MD3 = 1,0,1,0, so `md` = 4'b0101) and raises `supply_req` at the same time. Inhibit mode (MD0..MD3 = 1,0,1,1, so `md` = 4'b1101) follows only after `supply_ack` is high.
- R3: Each write attempt holds write mode (`md` = 4'b1110) for exactly UNIT_CYC cycles, with `bus_oe` high and the byte on `bus_out`. It is followed by inhibit and then by verify mode (`md` = 4'b1100).
- R4: When the read-back mismatches, another write attempt follows on the same address, with no X1 pulse in between.
- R5: After a matching verify, one extra write of exactly N × UNIT_CYC cycles is applied, where N is the number of write attempts that byte needed.
- R6: After the extra write, inhibit is selected and exactly X1_PULSES pulses appear on X1, each high for X1_HALF cycles. The next byte is fetched only after that, with the address one higher.
- R7: After the step that follows the byte at the end address, clear mode is selected and `supply_req` drops. `done` rises once `supply_ack` is low, and no byte beyond the end address is taken.
- R8: A byte that still mismatches after MAX_TRIES attempts gets no extra write. The block runs the clear/supply-down exit, raises `fail` (never together with `done`) and shows that byte's address on `fail_addr`. A byte that matches on exactly attempt MAX_TRIES is accepted.
- R9: `bus_oe` is high only in write mode. There is at least one cycle with `bus_oe` low and inhibit selected between a write and a verify, in either direction. `bus_in` is sampled only in verify mode.
- R10: `src_ready` is high only while inhibit is selected between bytes. Exactly one byte is taken per address.
- R11: X1 is low except during the address-step pulses, and those pulses occur only while inhibit is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run; accepted when idle or finished |
| end_addr | input | ADDR_W | Last address of the run, captured at start |
| src_valid | input | 1 | Byte source has a byte |
| src_data | input | DATA_W | Byte from the source |
| src_ready | output | 1 | Block takes the source byte this cycle if valid |
| md | output | 4 | Mode lines, bit 0 = MD0 |
| x1 | output | 1 | Address-step clock to the memory |
| supply_req | output | 1 | Request for programming supply levels |
| supply_ack | input | 1 | Supplies are at programming level |
| bus_out | output | DATA_W | Data driven to the memory during writes |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| bus_in | input | DATA_W | Data read back from the memory |
| done | output | 1 | Run completed with every byte verified |
| fail | output | 1 | Run stopped at the attempt limit |
| fail_addr | output | ADDR_W | Address of the byte that failed |

## Verification
Two decisions can land in the same cycle. At the last verify of a byte, the retry decision and the give-up decision are resolved by the same compare. At the last address, the end of the X1 step and the end-of-run decision also coincide. The bench's memory model lets each address need a chosen number of attempts. One byte needs exactly MAX_TRIES attempts and must be accepted with a full-length extra write. Another byte needs one more attempt and must end the run with `fail` at its address and no further fetch. Single-byte and multi-byte runs exercise the step-versus-finish case. A scoreboard fed by the run driver judges each byte's attempt count, pulse lengths and X1 pulse count against what the model required.

// File: rtl/prom_wv_pkg.sv
package prom_wv_pkg;

  // mode line codes, bit 0 = MD0
  localparam logic [3:0] MD_IDLE    = 4'b0000;
  localparam logic [3:0] MD_CLEAR   = 4'b0101;
  localparam logic [3:0] MD_WRITE   = 4'b1110;
  localparam logic [3:0] MD_VERIFY  = 4'b1100;
  localparam logic [3:0] MD_INHIBIT = 4'b1101;

  typedef enum logic [3:0] {
    S_IDLE, S_PWAIT, S_CLR_UP, S_GAP, S_FETCH, S_WRITE,
    S_VERIFY, S_OVER, S_STEP, S_CLR_DN, S_DONE
  } seq_state_t;

  // length of the final write: one unit per attempt used
  function automatic int unsigned overwrite_cycles(input int unsigned attempts,
                                                   input int unsigned unit);
    return attempts * unit;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prom_wv_timer.sv
module prom_wv_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         last
);
  logic [W-1:0] cnt;

  assign last = (cnt == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  // R3: a running interval shrinks by exactly one each cycle
  a_r3_timer_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/prom_wv_x1gen.sv
module prom_wv_x1gen #(
  parameter int HALF   = 1,
  parameter int PULSES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic x1,
  output logic last
);
  localparam int HW = (HALF   > 1) ? $clog2(HALF)   : 1;
  localparam int PW = (PULSES > 1) ? $clog2(PULSES) : 1;

  logic          active;
  logic          phase_hi;
  logic [HW-1:0] half;
  logic [PW-1:0] pcnt;
  logic          half_end;

  assign half_end = (half == HW'(HALF - 1));
  assign x1       = active && phase_hi;
  assign last     = active && !phase_hi && half_end && (pcnt == PW'(PULSES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      phase_hi <= 1'b0;
      half     <= '0;
      pcnt     <= '0;
    end else if (go) begin
      active   <= 1'b1;
      phase_hi <= 1'b1;
      half     <= '0;
      pcnt     <= '0;
    end else if (active) begin
      if (half_end) begin
        half     <= '0;
        phase_hi <= !phase_hi;
        if (!phase_hi) begin
          if (pcnt == PW'(PULSES - 1)) active <= 1'b0;
          else                         pcnt   <= pcnt + PW'(1);
        end
      end else begin
        half <= half + HW'(1);
      end
    end
  end

  // R6: a step burst is never restarted while it runs
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !active);
  // R6: after the last low phase the burst has stopped
  a_r6_burst_ends: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !x1);

endmodule

// File: rtl/prom_wv_seq.sv
module prom_wv_seq
  import prom_wv_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int UNIT_CYC   = 200000,
  parameter int POWER_WAIT = 2000,
  parameter int MAX_TRIES  = 25,
  parameter int GAP_CYC    = 2,
  parameter int VERIFY_CYC = 2,
  parameter int X1_HALF    = 1,
  parameter int X1_PULSES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic [3:0]        md,
  output logic              x1,
  output logic              supply_req,
  input  logic              supply_ack,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_in,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int unsigned LONGEST = max2(max2(UNIT_CYC * MAX_TRIES, POWER_WAIT),
                                         max2(GAP_CYC, VERIFY_CYC));
  localparam int CNT_W = $clog2(LONGEST + 1);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);

  seq_state_t        state, nxt;
  seq_state_t        gap_next, gap_next_d;
  logic [ADDR_W-1:0] addr, end_r;
  logic [DATA_W-1:0] byte_r;
  logic [TRY_W-1:0]  tries;
  logic              fail_pend;
  logic              done_r, fail_r;

  logic              tmr_load, tmr_last;
  logic [CNT_W-1:0]  tmr_val;
  logic              x1_go, x1_last;

  // named internal events
  logic fetch_take;
  logic sample_en;
  logic verify_pass;
  logic verify_retry;
  logic give_up;
  logic step_last;
  logic new_attempt;

  assign sample_en = (state == S_VERIFY) && tmr_last;

  always_comb begin
    nxt          = state;
    gap_next_d   = gap_next;
    tmr_load     = 1'b0;
    tmr_val      = '0;
    x1_go        = 1'b0;
    fetch_take   = 1'b0;
    verify_pass  = 1'b0;
    verify_retry = 1'b0;
    give_up      = 1'b0;
    step_last    = 1'b0;
    new_attempt  = 1'b0;
    case (state)
      S_IDLE, S_DONE: if (start) begin
        nxt      = S_PWAIT;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(POWER_WAIT);
      end
      S_PWAIT: if (tmr_last) nxt = S_CLR_UP;
      S_CLR_UP: if (supply_ack) begin
        nxt        = S_GAP;
        gap_next_d = S_FETCH;
        tmr_load   = 1'b1;
        tmr_val    = CNT_W'(GAP_CYC);
      end
      S_GAP: if (tmr_last) begin
        nxt = gap_next;
        case (gap_next)
          S_WRITE: begin
            tmr_load    = 1'b1;
            tmr_val     = CNT_W'(UNIT_CYC);
            new_attempt = 1'b1;
          end
          S_VERIFY: begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(VERIFY_CYC);
          end
          S_OVER: begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(overwrite_cycles(32'(tries), UNIT_CYC));
          end
          S_STEP:  x1_go = 1'b1;
          default: ;
        endcase
      end
      S_FETCH: if (src_valid) begin
        fetch_take = 1'b1;
        nxt        = S_WRITE;
        tmr_load   = 1'b1;
        tmr_val    = CNT_W'(UNIT_CYC);
      end
      S_WRITE: if (tmr_last) begin
        nxt        = S_GAP;
        gap_next_d = S_VERIFY;
        tmr_load   = 1'b1;
        tmr_val    = CNT_W'(GAP_CYC);
      end
      S_VERIFY: if (sample_en) begin
        if (bus_in == byte_r) begin
          verify_pass = 1'b1;
          nxt         = S_GAP;
          gap_next_d  = S_OVER;
          tmr_load    = 1'b1;
          tmr_val     = CNT_W'(GAP_CYC);
        end else if (tries == TRY_W'(MAX_TRIES)) begin
          give_up = 1'b1;
          nxt     = S_CLR_DN;
        end else begin
          verify_retry = 1'b1;
          nxt          = S_GAP;
          gap_next_d   = S_WRITE;
          tmr_load     = 1'b1;
          tmr_val      = CNT_W'(GAP_CYC);
        end
      end
      S_OVER: if (tmr_last) begin
        nxt        = S_GAP;
        gap_next_d = S_STEP;
        tmr_load   = 1'b1;
        tmr_val    = CNT_W'(GAP_CYC);
      end
      S_STEP: if (x1_last) begin
        if (addr == end_r) begin
          step_last = 1'b1;
          nxt       = S_CLR_DN;
        end else begin
          nxt = S_FETCH;
        end
      end
      S_CLR_DN: if (!supply_ack) nxt = S_DONE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      gap_next  <= S_FETCH;
      addr      <= '0;
      end_r     <= '0;
      byte_r    <= '0;
      tries     <= '0;
      fail_pend <= 1'b0;
      done_r    <= 1'b0;
      fail_r    <= 1'b0;
      fail_addr <= '0;
    end else begin
      state    <= nxt;
      gap_next <= gap_next_d;
      if ((state == S_IDLE || state == S_DONE) && start) begin
        addr      <= '0;
        end_r     <= end_addr;
        fail_pend <= 1'b0;
        done_r    <= 1'b0;
        fail_r    <= 1'b0;
      end
      if (fetch_take) begin
        byte_r <= src_data;
        tries  <= TRY_W'(1);
      end
      if (new_attempt) tries <= tries + TRY_W'(1);
      if (give_up) begin
        fail_pend <= 1'b1;
        fail_addr <= addr;
      end
      if (state == S_STEP && x1_last && !step_last) addr <= addr + ADDR_W'(1);
      if (state == S_CLR_DN && !supply_ack) begin
        if (fail_pend) fail_r <= 1'b1;
        else           done_r <= 1'b1;
      end
    end
  end

  prom_wv_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .last(tmr_last)
  );

  prom_wv_x1gen #(.HALF(X1_HALF), .PULSES(X1_PULSES)) u_x1 (
    .clk(clk), .rst_n(rst_n), .go(x1_go), .x1(x1), .last(x1_last)
  );

  always_comb begin
    case (state)
      S_CLR_UP, S_CLR_DN:    md = MD_CLEAR;
      S_GAP, S_FETCH, S_STEP: md = MD_INHIBIT;
      S_WRITE, S_OVER:       md = MD_WRITE;
      S_VERIFY:              md = MD_VERIFY;
      default:               md = MD_IDLE;
    endcase
  end

  assign supply_req = (state != S_IDLE) && (state != S_PWAIT) &&
                      (state != S_CLR_DN) && (state != S_DONE);
  assign bus_oe     = (state == S_WRITE) || (state == S_OVER);
  assign bus_out    = bus_oe ? byte_r : '0;
  assign src_ready  = (state == S_FETCH);
  assign done       = done_r;
  assign fail       = fail_r;

  // R9: the bus is driven only while write mode is shown
  a_r9_oe_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (md == MD_WRITE));
  // R9: a verify never directly follows a driven cycle
  a_r9_idle_before_verify: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MD_VERIFY) |-> !$past(bus_oe));
  // R9: the read-back is taken only in verify mode with the bus released
  a_r9_sample_in_verify: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (md == MD_VERIFY && !bus_oe));
  // R11: X1 pulses only under inhibit
  a_r11_x1_in_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    x1 |-> (md == MD_INHIBIT));
  // R10: source is offered only under inhibit with bus released
  a_r10_ready_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (md == MD_INHIBIT && !bus_oe && !x1));
  // R4: a retry write keeps the address
  a_r4_retry_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WRITE && $past(state) == S_GAP) |-> $stable(addr));
  // R6: a fetch after a step sees the next address
  a_r6_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && $past(state) == S_STEP) |-> (addr == $past(addr) + ADDR_W'(1)));
  // R8: completion and failure never show together
  a_r8_done_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  // R2: inhibit is only shown with the supply request raised
  a_r2_inhibit_powered: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MD_INHIBIT) |-> supply_req);

endmodule

// File: tb/tb_prom_wv_seq.sv
`timescale 1ns/1ps
module tb_prom_wv_seq;
  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int UNIT  = 8;
  localparam int PW    = 5;
  localparam int MAXT  = 4;
  localparam int GAP   = 2;
  localparam int VER   = 2;
  localparam int X1H   = 2;
  localparam int X1P   = 4;
  localparam logic [3:0] M_IDLE = 4'b0000, M_CLEAR = 4'b0101, M_WRITE = 4'b1110,
                         M_VERIFY = 4'b1100, M_INH = 4'b1101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] end_addr = '0;
  logic src_valid, src_ready;
  logic [DW-1:0] src_data;
  logic [3:0] md;
  logic x1, supply_req, supply_ack, bus_oe, done, fail;
  logic [DW-1:0] bus_out, bus_in;
  logic [AW-1:0] fail_addr;

  always #2.5 clk = ~clk;

  typedef struct { int addr; logic [7:0] data; int tries; bit fl; } item_t;
  item_t exp_q[$];
  int    lens[$];

  int n_chk = 0, n_fail = 0;
  logic [7:0] src_bytes [64];
  int need [64];
  int wcnt [64];
  logic [7:0] pmem [64];
  int maddr = 0, mx1 = 0;
  int src_idx = 0, run_last = 0;
  bit run_active = 1'b0;
  logic [2:0] ack_dly = '0;

  assign src_valid  = run_active && (src_idx <= run_last);
  assign src_data   = src_bytes[src_idx[5:0]];
  assign supply_ack = ack_dly[2];
  assign bus_in = (md == M_VERIFY) ?
                  ((wcnt[maddr[5:0]] >= need[maddr[5:0]]) ? pmem[maddr[5:0]] : ~pmem[maddr[5:0]]) :
                  8'h00;

  prom_wv_seq #(.ADDR_W(AW), .DATA_W(DW), .UNIT_CYC(UNIT), .POWER_WAIT(PW),
                .MAX_TRIES(MAXT), .GAP_CYC(GAP), .VERIFY_CYC(VER),
                .X1_HALF(X1H), .X1_PULSES(X1P)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .end_addr(end_addr),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .md(md), .x1(x1), .supply_req(supply_req), .supply_ack(supply_ack),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
    .done(done), .fail(fail), .fail_addr(fail_addr));

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // supply model: acknowledge follows request after a short delay
  initial forever begin
    @(negedge clk);
    ack_dly = {ack_dly[1:0], supply_req};
  end

  // memory model + scoreboard monitor
  logic [3:0] prev_md = 4'b0, last_act_md = 4'b0;
  bit prev_x1 = 0, prev_ready = 0, prev_fail = 0, prev_done = 0, data_bad = 0;
  int wr_len = 0, hi_len = 0, rises = 0;
  logic [7:0] last_wdata = '0;

  task automatic finalize_pass();
    item_t e;
    int n;
    if (exp_q.size() == 0) begin
      chk(0, "R5 unexpected byte", 1, 0);
      lens.delete();
      return;
    end
    e = exp_q.pop_front();
    n = lens.size() - 1;
    chk(!e.fl, "R8 byte expected to fail was accepted", 1, 0);
    chk(n == e.tries, "R4 write attempts for byte", n, e.tries);
    for (int i = 0; i < n; i++) chk(lens[i] == UNIT, "R3 attempt pulse length", lens[i], UNIT);
    chk(lens[n] == e.tries * UNIT, "R5 extra write length", lens[n], e.tries * UNIT);
    chk(!data_bad, "R3 write data on bus", data_bad, 0);
    data_bad = 0;
    lens.delete();
    rises = 0;
  endtask

  task automatic finalize_fail();
    item_t e;
    if (exp_q.size() == 0) begin
      chk(0, "R8 unexpected fail", 1, 0);
      return;
    end
    e = exp_q.pop_front();
    chk(e.fl, "R8 fail raised for a byte that should pass", 0, 1);
    chk(lens.size() == MAXT, "R8 attempts before giving up, no extra write", lens.size(), MAXT);
    foreach (lens[i]) chk(lens[i] == UNIT, "R3 attempt pulse length", lens[i], UNIT);
    chk(int'(fail_addr) == e.addr, "R8 fail address", fail_addr, e.addr);
    lens.delete();
    data_bad = 0;
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (md == M_CLEAR) begin maddr = 0; mx1 = 0; end
      if (prev_md == M_WRITE && md != M_WRITE) begin
        wcnt[maddr[5:0]]++;
        pmem[maddr[5:0]] = last_wdata;
        lens.push_back(wr_len);
        wr_len = 0;
      end
      if (md == M_WRITE) begin
        wr_len++;
        last_wdata = bus_out;
        if (exp_q.size() > 0 && (!bus_oe || bus_out != exp_q[0].data)) data_bad = 1;
      end
      if (md == M_VERIFY && prev_md != M_VERIFY)
        chk(!bus_oe && prev_md == M_INH, "R9 verify entered from released inhibit", bus_oe, 0);
      if (x1 && !prev_x1) begin
        if (lens.size() > 0) finalize_pass();
        rises++;
        mx1++;
        if (mx1 == X1P) begin mx1 = 0; maddr++; end
      end
      if (x1) begin
        hi_len++;
        chk(md == M_INH, "R11 x1 under inhibit", md, M_INH);
      end
      if (!x1 && prev_x1) begin
        chk(hi_len == X1H, "R6 x1 high width", hi_len, X1H);
        hi_len = 0;
      end
      if (prev_ready && !src_ready && md == M_WRITE) begin
        if (src_idx > 0) chk(rises == X1P, "R6 x1 pulses per step", rises, X1P);
        rises = 0;
        chk(maddr == src_idx, "R10 byte taken at its own address", maddr, src_idx);
        src_idx++;
      end
      if (fail && !prev_fail) finalize_fail();
      if (done && !prev_done) begin
        chk(rises == X1P, "R6 x1 pulses on last step", rises, X1P);
        rises = 0;
      end
      if (md != M_IDLE) last_act_md = md;
      prev_md = md; prev_x1 = x1; prev_ready = src_ready;
      prev_fail = fail; prev_done = done;
    end
  end

  task automatic run(input int last, input int fail_at);
    int cnt;
    item_t it;
    for (int i = 0; i < 64; i++) wcnt[i] = 0;
    for (int i = 0; i <= last; i++) begin
      it.addr = i; it.data = src_bytes[i];
      it.fl = (need[i] > MAXT);
      it.tries = it.fl ? MAXT : need[i];
      exp_q.push_back(it);
      if (it.fl) break;
    end
    run_last = last;
    end_addr = AW'(last);
    run_active = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!done && !fail, "R1 status cleared by start", done | fail, 0);
    cnt = 0;
    while (md == M_IDLE && cnt < 1000) begin cnt++; @(negedge clk); end
    chk(cnt == PW, "R2 power wait length", cnt, PW);
    chk(md == M_CLEAR && supply_req, "R2 clear mode with supply request", md, M_CLEAR);
    cnt = 0;
    while (md == M_CLEAR && cnt < 1000) begin cnt++; @(negedge clk); end
    chk(md == M_INH && supply_ack, "R2 inhibit only after acknowledge", md, M_INH);
    cnt = 0;
    while (!done && !fail && cnt < 20000) begin cnt++; @(negedge clk); end
    if (fail_at < 0) begin
      chk(done && !fail, "R7 run completes", done, 1);
      chk(src_idx == last + 1, "R7 byte count taken", src_idx, last + 1);
    end else begin
      chk(fail && !done, "R8 run fails", fail, 1);
      chk(src_idx == fail_at + 1, "R8 no fetch after failing byte", src_idx, fail_at + 1);
    end
    chk(!supply_req && !supply_ack, "R7 supplies lowered", supply_req, 0);
    chk(last_act_md == M_CLEAR && md == M_IDLE, "R7 clear mode before finish", last_act_md, M_CLEAR);
    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    chk(!x1 && !bus_oe && !src_ready, "R11 quiet after finish", x1, 0);
    run_active = 1'b0;
    @(negedge clk);
    src_idx = 0;
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin src_bytes[i] = 8'h00; need[i] = 1; pmem[i] = 8'h00; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(md == M_IDLE, "R1 mode lines idle", md, M_IDLE);
    chk(!x1 && !bus_oe, "R1 x1 and bus released", x1 | bus_oe, 0);
    chk(!supply_req && !src_ready, "R1 no request, not ready", supply_req | src_ready, 0);
    chk(!done && !fail, "R1 no status", done | fail, 0);

    // four bytes; one passes exactly at the attempt limit
    src_bytes[0] = 8'hA5; need[0] = 1;
    src_bytes[1] = 8'h3C; need[1] = 3;
    src_bytes[2] = 8'hF0; need[2] = MAXT;
    src_bytes[3] = 8'h5A; need[3] = 2;
    run(3, -1);

    // single byte: step and finish decided together
    src_bytes[0] = 8'h81; need[0] = 2;
    run(0, -1);

    // second byte never verifies within the limit
    src_bytes[0] = 8'h11; need[0] = 1;
    src_bytes[1] = 8'h22; need[1] = MAXT + 1;
    src_bytes[2] = 8'h33; need[2] = 1;
    src_bytes[3] = 8'h44; need[3] = 1;
    run(3, 1);

    // restart after a failed run
    src_bytes[0] = 8'hC3; need[0] = 1;
    src_bytes[1] = 8'h7E; need[1] = 1;
    run(1, -1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule